// File: doc/BRIEF.md
# Debug Memory Access Sequencer

The sequencer stands between a memory-access requester and a debug link master that injects single instructions into a halted 8-bit target. A request names one of five byte accesses (code-memory read, external-data read or write, internal-RAM read or write), an address and a write value. The sequencer turns it into a fixed script of injected instructions. Each script step is handed to the link master as a declared length (1 to 3) and three payload bytes. The sequencer waits for the master's done before issuing the next step.

After the last step the sequencer pulses its own done. For read requests it presents the byte the target returned for the final step. Code-memory reads pick a memory bank from the upper address bits by injecting a bank-select write first. A separate input path decodes the first chip ID byte into the target's flash word size. That size is kept for later use by other logic.

Top module: `dbgseq_top`

## Requirements
- R1: Request op encoding is 0 = code read, 1 = external-data read, 2 = external-data write, 3 = internal-RAM read, 4 = internal-RAM write. A start strobe with op 5..7 is ignored: busy stays low, no link transaction starts and no done pulse follows.
- R2: A code read with address A injects, in order, three steps. The first is len 3 {0x75, 0xC7, (A[16:15]<<4)+1}. The second is len 3 {0x90, {1'b0,A[14:8]}, A[7:0]}. The third is len 2 {0xE4,0,0}. A fourth step, len 3 {0x93,0,0}, is the final one.
- R3: An external-data read injects len 3 {0x90, A[15:8], A[7:0]}. It then injects len 3 {0xE0,0,0}, which is final.
- R4: An external-data write with value V injects len 3 {0x90, A[15:8], A[7:0]}, then len 2 {0x74, V, 0}. Its final step is len 1 {0xF0,0,0}.
- R5: An internal-RAM read injects len 2 {0xE4,0,0}. It then injects len 3 {0xE5, A[7:0], 0}, which is final.
- R6: An internal-RAM write injects len 2 {0xE4,0,0}. It then injects len 3 {0x75, A[7:0], V}, which is final.
- R7: Every payload byte not named in the step's script above is driven as zero, including bytes inside the declared length.
- R8: Each step raises lnk_start_o for exactly one cycle. The next step starts only after lnk_done_i has been seen, and the payload and length hold steady while waiting.
- R9: busy_o is high from the cycle after acceptance until the final lnk_done_i is seen. In the next cycle done_o is high for one cycle with busy_o low.
- R10: For reads, rdata_o takes the lnk_rdata_i byte that came with the final step's done and holds it. Write requests leave rdata_o unchanged.
- R11: A start strobe arriving while busy_o is high is ignored. It neither alters the running script nor starts a later one.
- R12: When id_valid_i is high, the byte on id_byte_i sets word_size_o one cycle later. 0x01, 0x11, 0x81 and 0x91 give 2. 0x85 and 0x89 give 4. Any other byte leaves word_size_o unchanged.
- R13: After reset busy_o, done_o, lnk_start_o, rdata_o and word_size_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request start strobe |
| req_op_i | input | 3 | Request type |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | 8 | Write value |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read result |
| lnk_start_o | output | 1 | Start one injected-instruction transaction |
| lnk_len_o | output | 2 | Declared instruction length |
| lnk_b0_o | output | 8 | Payload byte 0 (opcode) |
| lnk_b1_o | output | 8 | Payload byte 1 |
| lnk_b2_o | output | 8 | Payload byte 2 |
| lnk_done_i | input | 1 | Link transaction complete |
| lnk_rdata_i | input | 8 | Target reply byte |
| id_valid_i | input | 1 | Chip ID byte valid |
| id_byte_i | input | 8 | First chip ID byte |
| word_size_o | output | 3 | Flash word size in bytes (0 unknown) |

## Verification
The bench covers three bank values in code reads: bank 3, bank 0, and an address exactly at the bank 1 boundary. A wrong slice or shift of the bank bits shows up as a wrong third byte in the first step, and a missing 7-bit mask shows up as bit 7 set in the pointer high byte. Link latency is varied, and a second request is thrown in mid-script. A sequencer that skipped the done handshake would emit steps back to back, and one that accepted the late request would record extra transactions. The bench captures the reply byte of every step and expects only the last one, so a sequencer latching an earlier reply returns the wrong value; a write that followed a read must leave the earlier result untouched. Chip ID bytes outside both lists, sent after a known size, catch a decoder that defaults instead of holding.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  typedef enum logic [2:0] {
    OP_CODE_RD  = 3'd0,
    OP_XDATA_RD = 3'd1,
    OP_XDATA_WR = 3'd2,
    OP_IRAM_RD  = 3'd3,
    OP_IRAM_WR  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } st_e;

  typedef struct packed {
    logic [1:0] len;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
    logic       last;
    logic       capture;
  } step_t;

  localparam logic [7:0] INS_MOV_DIR_IMM = 8'h75;
  localparam logic [7:0] INS_MOV_DPTR    = 8'h90;
  localparam logic [7:0] INS_CLR_A       = 8'hE4;
  localparam logic [7:0] INS_MOVC_A      = 8'h93;
  localparam logic [7:0] INS_MOV_A_IMM   = 8'h74;
  localparam logic [7:0] INS_MOVX_WR     = 8'hF0;
  localparam logic [7:0] INS_MOVX_RD     = 8'hE0;
  localparam logic [7:0] INS_MOV_A_DIR   = 8'hE5;
  localparam logic [7:0] SFR_BANK_SEL    = 8'hC7;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic step_t mk_step(input logic [1:0] len, input logic [7:0] b0,
                                    input logic [7:0] b1, input logic [7:0] b2,
                                    input logic last, input logic capture);
    step_t s;
    s.len = len; s.b0 = b0; s.b1 = b1; s.b2 = b2;
    s.last = last; s.capture = capture;
    return s;
  endfunction

endpackage

// File: rtl/dbgseq_script.sv
module dbgseq_script
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int STEP_W = 2
) (
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output step_t             step_o
);

  logic [1:0] bank;
  logic [7:0] bank_byte;
  logic [7:0] ahi;
  logic [7:0] ahi7;
  logic [7:0] alo;

  assign bank      = addr_i[16:15];
  assign bank_byte = {2'b00, bank, 4'b0001};
  assign ahi       = addr_i[15:8];
  assign ahi7      = {1'b0, addr_i[14:8]};
  assign alo       = addr_i[7:0];

  always_comb begin
    step_o = mk_step(2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
    case (op_i)
      OP_CODE_RD: begin
        case (step_i)
          2'd0:    step_o = mk_step(2'd3, INS_MOV_DIR_IMM, SFR_BANK_SEL, bank_byte, 1'b0, 1'b0);
          2'd1:    step_o = mk_step(2'd3, INS_MOV_DPTR, ahi7, alo, 1'b0, 1'b0);
          2'd2:    step_o = mk_step(2'd2, INS_CLR_A, 8'h00, 8'h00, 1'b0, 1'b0);
          default: step_o = mk_step(2'd3, INS_MOVC_A, 8'h00, 8'h00, 1'b1, 1'b1);
        endcase
      end
      OP_XDATA_RD: begin
        if (step_i == '0) step_o = mk_step(2'd3, INS_MOV_DPTR, ahi, alo, 1'b0, 1'b0);
        else              step_o = mk_step(2'd3, INS_MOVX_RD, 8'h00, 8'h00, 1'b1, 1'b1);
      end
      OP_XDATA_WR: begin
        case (step_i)
          2'd0:    step_o = mk_step(2'd3, INS_MOV_DPTR, ahi, alo, 1'b0, 1'b0);
          2'd1:    step_o = mk_step(2'd2, INS_MOV_A_IMM, wdata_i, 8'h00, 1'b0, 1'b0);
          default: step_o = mk_step(2'd1, INS_MOVX_WR, 8'h00, 8'h00, 1'b1, 1'b0);
        endcase
      end
      OP_IRAM_RD: begin
        if (step_i == '0) step_o = mk_step(2'd2, INS_CLR_A, 8'h00, 8'h00, 1'b0, 1'b0);
        else              step_o = mk_step(2'd3, INS_MOV_A_DIR, alo, 8'h00, 1'b1, 1'b1);
      end
      OP_IRAM_WR: begin
        if (step_i == '0) step_o = mk_step(2'd2, INS_CLR_A, 8'h00, 8'h00, 1'b0, 1'b0);
        else              step_o = mk_step(2'd3, INS_MOV_DIR_IMM, alo, wdata_i, 1'b1, 1'b0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dbgseq_ctrl.sv
module dbgseq_ctrl
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int STEP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  input  step_t             cur_step_i,
  input  logic              lnk_done_i,
  input  logic [7:0]        lnk_rdata_i,
  output op_e               op_o,
  output logic [STEP_W-1:0] step_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              lnk_start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rdata_o
);

  st_e               st_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;
  logic              done_q;
  logic [7:0]        rdata_q;
  logic              accept;

  assign accept = (st_q == ST_IDLE) && req_valid_i && op_known(req_op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_CODE_RD;
      step_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_e'(req_op_i);
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            step_q  <= '0;
            st_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (lnk_done_i) begin
            if (cur_step_i.last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              if (cur_step_i.capture) rdata_q <= lnk_rdata_i;
            end else begin
              step_q <= step_q + 1'b1;
              st_q   <= ST_ISSUE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign op_o        = op_q;
  assign step_o      = step_q;
  assign addr_o      = addr_q;
  assign wdata_o     = wdata_q;
  assign lnk_start_o = (st_q == ST_ISSUE);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_start_o |=> !lnk_start_o); // R8
  AST_START_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lnk_start_o |-> (cur_step_i.len != 2'd0)); // R8
  AST_PAYLOAD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> $stable(cur_step_i)); // R8
  AST_WAIT_FOR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !lnk_done_i) |=> !lnk_start_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R9
  AST_BAD_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_op_i > 3'd4) |=> !busy_o); // R1
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> $stable(addr_o)); // R11

endmodule

// File: rtl/dbgseq_wordsize.sv
module dbgseq_wordsize #(
  parameter int WS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            id_valid_i,
  input  logic [7:0]      id_byte_i,
  output logic [WS_W-1:0] word_size_o
);

  logic [WS_W-1:0] ws_q;
  logic            is_two;
  logic            is_four;

  always_comb begin
    is_two  = 1'b0;
    is_four = 1'b0;
    case (id_byte_i)
      8'h01, 8'h11, 8'h81, 8'h91: is_two  = 1'b1;
      8'h85, 8'h89:               is_four = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ws_q <= '0;
    else if (id_valid_i && is_two)  ws_q <= WS_W'(2);
    else if (id_valid_i && is_four) ws_q <= WS_W'(4);
  end

  assign word_size_o = ws_q;

  AST_WS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_size_o == '0) || (word_size_o == WS_W'(2)) || (word_size_o == WS_W'(4))); // R12
  AST_WS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |=> $stable(word_size_o)); // R12

endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
  import dbgseq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int WS_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [7:0]        req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic              lnk_start_o,
  output logic [1:0]        lnk_len_o,
  output logic [7:0]        lnk_b0_o,
  output logic [7:0]        lnk_b1_o,
  output logic [7:0]        lnk_b2_o,
  input  logic              lnk_done_i,
  input  logic [7:0]        lnk_rdata_i,
  input  logic              id_valid_i,
  input  logic [7:0]        id_byte_i,
  output logic [WS_W-1:0]   word_size_o
);

  localparam int MAX_STEPS = 4;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  op_e               op;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata;
  step_t             cur_step;

  dbgseq_ctrl #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .cur_step_i  (cur_step),
    .lnk_done_i  (lnk_done_i),
    .lnk_rdata_i (lnk_rdata_i),
    .op_o        (op),
    .step_o      (step),
    .addr_o      (addr),
    .wdata_o     (wdata),
    .lnk_start_o (lnk_start_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o)
  );

  dbgseq_script #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_script (
    .op_i    (op),
    .step_i  (step),
    .addr_i  (addr),
    .wdata_i (wdata),
    .step_o  (cur_step)
  );

  dbgseq_wordsize #(.WS_W(WS_W)) u_ws (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_valid_i  (id_valid_i),
    .id_byte_i   (id_byte_i),
    .word_size_o (word_size_o)
  );

  assign lnk_len_o = cur_step.len;
  assign lnk_b0_o  = cur_step.b0;
  assign lnk_b1_o  = cur_step.b1;
  assign lnk_b2_o  = cur_step.b2;

endmodule

// File: tb/dbgseq_top_tb.sv
module dbgseq_top_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_op_i = '0;
  logic [16:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        busy_o, done_o, lnk_start_o;
  logic [7:0]  rdata_o, lnk_b0_o, lnk_b1_o, lnk_b2_o;
  logic [1:0]  lnk_len_o;
  logic        lnk_done_i;
  logic [7:0]  lnk_rdata_i;
  logic        id_valid_i = 1'b0;
  logic [7:0]  id_byte_i = '0;
  logic [2:0]  word_size_o;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int tx_n = 0;
  int done_n = 0;
  logic [7:0] reply_base = 8'h40;
  logic [1:0] tx_len [8];
  logic [7:0] tx_b0 [8];
  logic [7:0] tx_b1 [8];
  logic [7:0] tx_b2 [8];

  always #5 clk = ~clk;

  dbgseq_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .lnk_start_o(lnk_start_o),
    .lnk_len_o(lnk_len_o), .lnk_b0_o(lnk_b0_o), .lnk_b1_o(lnk_b1_o),
    .lnk_b2_o(lnk_b2_o), .lnk_done_i(lnk_done_i), .lnk_rdata_i(lnk_rdata_i),
    .id_valid_i(id_valid_i), .id_byte_i(id_byte_i), .word_size_o(word_size_o)
  );

  // link master model: record each start, answer after lat cycles
  initial begin
    lnk_done_i  = 1'b0;
    lnk_rdata_i = 8'h00;
    forever begin
      @(negedge clk);
      lnk_done_i = 1'b0;
      if (lnk_start_o) begin
        if (tx_n < 8) begin
          tx_len[tx_n] = lnk_len_o;
          tx_b0[tx_n]  = lnk_b0_o;
          tx_b1[tx_n]  = lnk_b1_o;
          tx_b2[tx_n]  = lnk_b2_o;
        end
        lnk_rdata_i = reply_base + 8'(tx_n);
        tx_n = tx_n + 1;
        repeat (lat) @(negedge clk);
        lnk_done_i = 1'b1;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (done_o) done_n = done_n + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_tx(input string tag, input int i, input int len,
                        input int b0, input int b1, input int b2);
    chk({tag, " len"}, int'(tx_len[i]), len);
    chk({tag, " b0"},  int'(tx_b0[i]),  b0);
    chk({tag, " b1"},  int'(tx_b1[i]),  b1);
    chk({tag, " b2"},  int'(tx_b2[i]),  b2);
  endtask

  task automatic launch(input logic [2:0] op, input logic [16:0] a, input logic [7:0] v);
    tx_n   = 0;
    done_n = 0;
    @(negedge clk);
    req_op_i = op; req_addr_i = a; req_wdata_i = v; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, int'(done_o), 1);
    chk({tag, " busy low at done"}, int'(busy_o), 0);
    @(negedge clk);
    chk({tag, " done one cycle"}, int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R13 busy", int'(busy_o), 0);
    chk("R13 done", int'(done_o), 0);
    chk("R13 start", int'(lnk_start_o), 0);
    chk("R13 rdata", int'(rdata_o), 0);
    chk("R13 wsize", int'(word_size_o), 0);
  endtask

  task automatic t_code_rd(input logic [16:0] a, input int l);
    int bank_b;
    lat = l;
    bank_b = ((int'(a) >> 15) & 3) * 16 + 1;
    launch(3'd0, a, 8'h00);
    chk("R9 busy after accept", int'(busy_o), 1);
    wait_done("R9 code rd");
    chk("R2 tx count", tx_n, 4);
    chk_tx("R2 bank sel", 0, 3, 'h75, 'hC7, bank_b);
    chk_tx("R2 dptr", 1, 3, 'h90, (int'(a) >> 8) & 'h7F, int'(a) & 'hFF);
    chk_tx("R7 clr pad", 2, 2, 'hE4, 0, 0);
    chk_tx("R2 movc", 3, 3, 'h93, 0, 0);
    chk("R10 code rdata", int'(rdata_o), int'(reply_base) + 3);
  endtask

  task automatic t_xdata_rd(input logic [16:0] a);
    lat = 2;
    launch(3'd1, a, 8'h00);
    wait_done("R9 xd rd");
    chk("R3 tx count", tx_n, 2);
    chk_tx("R3 dptr", 0, 3, 'h90, (int'(a) >> 8) & 'hFF, int'(a) & 'hFF);
    chk_tx("R3 movx", 1, 3, 'hE0, 0, 0);
    chk("R10 xd rdata", int'(rdata_o), int'(reply_base) + 1);
  endtask

  task automatic t_xdata_wr(input logic [16:0] a, input logic [7:0] v);
    logic [7:0] prev;
    prev = rdata_o;
    lat = 1;
    launch(3'd2, a, v);
    wait_done("R9 xd wr");
    chk("R4 tx count", tx_n, 3);
    chk_tx("R4 dptr", 0, 3, 'h90, (int'(a) >> 8) & 'hFF, int'(a) & 'hFF);
    chk_tx("R4 mov a", 1, 2, 'h74, int'(v), 0);
    chk_tx("R4 movx", 2, 1, 'hF0, 0, 0);
    chk("R10 write keeps rdata", int'(rdata_o), int'(prev));
  endtask

  task automatic t_iram_rd(input logic [7:0] a);
    lat = 3;
    launch(3'd3, {9'h1AB, a}, 8'h00);
    wait_done("R9 ir rd");
    chk("R5 tx count", tx_n, 2);
    chk_tx("R5 clr", 0, 2, 'hE4, 0, 0);
    chk_tx("R5 mov", 1, 3, 'hE5, int'(a), 0);
    chk("R10 ir rdata", int'(rdata_o), int'(reply_base) + 1);
  endtask

  task automatic t_iram_wr(input logic [7:0] a, input logic [7:0] v);
    logic [7:0] prev;
    prev = rdata_o;
    lat = 1;
    launch(3'd4, {9'h000, a}, v);
    wait_done("R9 ir wr");
    chk("R6 tx count", tx_n, 2);
    chk_tx("R6 clr", 0, 2, 'hE4, 0, 0);
    chk_tx("R6 mov", 1, 3, 'h75, int'(a), int'(v));
    chk("R10 ir wr keeps rdata", int'(rdata_o), int'(prev));
  endtask

  task automatic t_bad_op();
    for (int op = 5; op < 8; op++) begin
      launch(3'(op), 17'h00123, 8'h55);
      chk("R1 bad op busy", int'(busy_o), 0);
      repeat (6) @(negedge clk);
      chk("R1 bad op no tx", tx_n, 0);
      chk("R1 bad op no done", done_n, 0);
    end
  endtask

  task automatic t_busy_ignore();
    lat = 3;
    launch(3'd3, 17'h00022, 8'h00);
    repeat (2) @(negedge clk);
    req_op_i = 3'd2; req_addr_i = 17'h0BEEF; req_wdata_i = 8'h99; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    wait_done("R11 first");
    repeat (10) @(negedge clk);
    chk("R11 tx count", tx_n, 2);
    chk("R11 single done", done_n, 1);
    chk("R11 idle", int'(busy_o), 0);
    chk_tx("R11 script kept", 1, 3, 'hE5, 'h22, 0);
  endtask

  task automatic send_id(input logic [7:0] b, input int exp, input string tag);
    @(negedge clk);
    id_byte_i = b; id_valid_i = 1'b1;
    @(negedge clk);
    id_valid_i = 1'b0;
    chk(tag, int'(word_size_o), exp);
  endtask

  task automatic t_chip_id();
    send_id(8'h55, 0, "R12 unknown from reset");
    send_id(8'h81, 2, "R12 0x81");
    send_id(8'h3C, 2, "R12 other holds 2");
    send_id(8'h89, 4, "R12 0x89");
    send_id(8'h00, 4, "R12 other holds 4");
    send_id(8'h11, 2, "R12 0x11");
    send_id(8'h85, 4, "R12 0x85");
    send_id(8'h01, 2, "R12 0x01");
    send_id(8'h85, 4, "R12 0x85 again");
    send_id(8'h91, 2, "R12 0x91");
    @(negedge clk);
    id_byte_i = 8'h89;
    @(negedge clk);
    chk("R12 no valid no change", int'(word_size_o), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_bad_op();
    t_code_rd(17'h1A5C3, 1);
    t_code_rd(17'h04321, 3);
    t_code_rd(17'h08000, 2);
    t_xdata_rd(17'h0F00D);
    t_xdata_wr(17'h0F123, 8'hA7);
    t_iram_rd(8'h7E);
    t_iram_wr(8'h30, 8'h5A);
    t_busy_ignore();
    t_chip_id();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule